// File: doc/BRIEF.md
# Waveform Timer Counter Channel

This block is a single up-counting timer channel. It is controlled through a small register bus. Software chooses a count source: one of four internally divided clocks, or an external chain input. Software also loads two compare values, A and C, and then starts the channel with a command write. The channel runs in one of two modes:

- **Free-running:** the counter wraps at full scale.
- **Reload:** the counter returns to zero after it reaches compare C.

A stop flag makes the channel fire once and then go idle. A waveform output goes high on an A match and low on a C match.

Three event flags can raise an interrupt:

- a wrap at full scale,
- an A match,
- a C match.

Each flag is masked through separate set and clear registers. Reading the status register clears the flags.

Two channels can be paired into a 32-bit counter. The waveform output of the low channel, configured with A=0 and C=0x8000 in free-running mode, rises once per full count. That output feeds the chain input of the high channel, which is set to the external source. A shared sync strobe restarts every channel at the same edge, as a software trigger does.

Top module: `wtc_channel`

## Requirements
- R1: After reset, every register reads 0: count, status, interrupt mask and mode. `wave_out` and `irq_out` are low.
- R2: In free-running mode (mode bit 3 = 0) the count wraps from 0xFFFF to 0. That step sets the wrap flag, which is status bit 0.
- R3: In reload mode (mode bit 3 = 1), a count tick taken while the count equals compare C loads 0. This gives a period of C+1 ticks.
- R4: When mode bit 4 is set, a tick taken at a C match also clears the running state, which is status bit 8. The count then holds until a new start.
- R5: A command write decodes bit 0 as start, bit 1 as halt and bit 2 as trigger. Halt wins over start. The trigger zeroes the count and the prescaler, and it does not change the running state.
- R6: `wave_out` rises after a tick taken at an A match and falls after a tick taken at a C match; if both match on the same tick, the C match wins. With A=0 and C=0x8000 in free-running mode, the output is high for exactly half of the time.
- R7: An A match sets status bit 1 and a C match sets status bit 2. A status read clears the flags at its edge, but an event at that same edge keeps its flag set. Status bit 9 shows the `wave_out` level.
- R8: A write to the mask-set register (address 6) ORs data bits 2:0 into the mask. A write to the mask-clear register (address 7) removes those bits, so writing 0xFF masks every source. The mask reads back at address 8.
- R9: `irq_out` is high exactly when a set flag is also unmasked. It follows the flag registers with no added cycle.
- R10: Mode bits 2:0 with values 0 to 3 select a tick every 4^sel clocks. The first tick after a trigger falls on the 4^sel-th clock.
- R11: Mode bits 2:0 with a value of 4 or more select the chain input. The input passes through two synchronizer flops, and each rising edge advances the count once. The new count is visible three clocks after the input rises.
- R12: A one-cycle pulse on `sync_in` zeroes the count and the prescaler in the same way as a trigger command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of status clears its flags |
| bus_addr | input | 4 | Register address: 0 command, 1 mode, 2 compare A, 3 compare C, 4 count, 5 status, 6 mask set, 7 mask clear, 8 mask |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from `bus_addr` |
| sync_in | input | 1 | Shared restart strobe |
| chain_in | input | 1 | External count input, asynchronous |
| wave_out | output | 1 | Compare-driven waveform |
| irq_out | output | 1 | Channel interrupt |

## Verification
Each bus access takes one cycle. Read data is available in the same cycle, and a write or command takes effect at the edge that ends the access. While the channel counts every clock, the count seen N cycles after a trigger is therefore N-1. Flags, `wave_out` and `irq_out` change at the edge of the matching tick. A chain edge shows up in the count three edges after it arrives.

The bench drives every access from a falling edge and samples there. It counts rising edges from the command edge to place each expected value: a status read that coincides with a new match, the first prescaled tick, and the synchronizer delay.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int ADDR_W = 4;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] A_CMD   = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CMPA  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMPC  = 4'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd4;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
    localparam logic [ADDR_W-1:0] A_ISET  = 4'd6;
    localparam logic [ADDR_W-1:0] A_ICLR  = 4'd7;
    localparam logic [ADDR_W-1:0] A_IMASK = 4'd8;

    localparam int CMD_START = 0;
    localparam int CMD_HALT  = 1;
    localparam int CMD_KICK  = 2;

    localparam int ST_RUN  = 8;
    localparam int ST_WAVE = 9;

    typedef struct packed {
        logic             stop_on_c;
        logic             reload;
        logic [SEL_W-1:0] src;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic c_hit;
        logic a_hit;
        logic wrap;
    } evt_t;

    localparam int EVT_W = $bits(evt_t);

    typedef struct packed {
        logic start;
        logic halt;
        logic clr;
    } ctl_t;

endpackage

// File: rtl/wtc_tick_gen.sv
module wtc_tick_gen
    import wtc_pkg::*;
#(
    parameter int NUM_DIV = 4,
    parameter int DIV_LOG = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SEL_W-1:0] src,
    input  logic             ext_in,
    output logic             tick
);
    localparam int PRE_W = DIV_LOG * (NUM_DIV - 1);

    logic [PRE_W-1:0]   pre_q;
    logic [NUM_DIV-1:0] div_tick;
    logic               sync1_q, sync2_q, prev_q;
    logic               ext_tick;

    always_ff @(posedge clk) begin
        if (rst || clr) pre_q <= '0;
        else            pre_q <= pre_q + 1'b1;
    end

    assign div_tick[0] = 1'b1;
    generate
        for (genvar k = 1; k < NUM_DIV; k++) begin : g_div
            assign div_tick[k] = &pre_q[DIV_LOG*k-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= ext_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign ext_tick = sync2_q & ~prev_q;

    always_comb begin
        tick = ext_tick;
        for (int k = 0; k < NUM_DIV; k++) begin
            if (src == SEL_W'(k)) tick = div_tick[k];
        end
    end

    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ext_tick |=> !ext_tick); // R11

endmodule

// File: rtl/wtc_core.sv
module wtc_core
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ctl_t             ctl,
    input  logic             reload,
    input  logic             stop_on_c,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_c,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             wave,
    output evt_t             evt
);
    logic adv, at_a, at_c;

    always_comb begin
        adv       = running & tick & ~ctl.clr;
        at_a      = (cnt == cmp_a);
        at_c      = (cnt == cmp_c);
        evt.wrap  = adv & (&cnt);
        evt.a_hit = adv & at_a;
        evt.c_hit = adv & at_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
            wave    <= 1'b0;
        end else begin
            if (ctl.halt)                        running <= 1'b0;
            else if (ctl.start)                  running <= 1'b1;
            else if (evt.c_hit && stop_on_c)     running <= 1'b0;

            if (ctl.clr)                         cnt <= '0;
            else if (adv)                        cnt <= (reload && at_c) ? '0 : cnt + 1'b1;

            if (evt.c_hit)                       wave <= 1'b0;
            else if (evt.a_hit)                  wave <= 1'b1;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!running && !ctl.clr) |=> $stable(cnt)); // R4

    AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (rst)
        (evt.c_hit && stop_on_c && !ctl.start) |=> !running); // R4

    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (evt.c_hit && reload) |=> (cnt == '0)); // R3

    AST_WAVE_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(wave) |-> $past(evt.a_hit)); // R6

    AST_HALT_WINS: assert property (@(posedge clk) disable iff (rst)
        ctl.halt |=> !running); // R5

endmodule

// File: rtl/wtc_irq.sv
module wtc_irq
    import wtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  logic             rd_clear,
    input  logic [EVT_W-1:0] mask_set,
    input  logic [EVT_W-1:0] mask_clr,
    output evt_t             flags,
    output logic [EVT_W-1:0] mask,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            flags <= evt_t'((rd_clear ? '0 : flags) | evt);
            mask  <= (mask | mask_set) & ~mask_clr;
        end
    end

    assign irq = |(flags & mask);

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && evt == '0) |=> (flags == '0)); // R7

    AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
        (&mask_clr) |=> (mask == '0)); // R8

    AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0 && mask != '0)); // R9

endmodule

// File: rtl/wtc_channel.sv
module wtc_channel
    import wtc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_DIV = 4,
    parameter int DIV_LOG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              sync_in,
    input  logic              chain_in,
    output logic              wave_out,
    output logic              irq_out
);
    mode_t            mode_q;
    logic [CNT_W-1:0] cmp_a_q, cmp_c_q;
    logic [CNT_W-1:0] cnt;
    logic             running, tick, wr_cmd, rd_clear;
    ctl_t             ctl;
    evt_t             evt, flags;
    logic [EVT_W-1:0] mask, mask_set, mask_clr;

    always_comb begin
        wr_cmd    = bus_wr && (bus_addr == A_CMD);
        ctl.start = wr_cmd && bus_wdata[CMD_START];
        ctl.halt  = wr_cmd && bus_wdata[CMD_HALT];
        ctl.clr   = (wr_cmd && bus_wdata[CMD_KICK]) || sync_in;
        mask_set  = (bus_wr && bus_addr == A_ISET) ? bus_wdata[EVT_W-1:0] : '0;
        mask_clr  = (bus_wr && bus_addr == A_ICLR) ? bus_wdata[EVT_W-1:0] : '0;
        rd_clear  = bus_rd && (bus_addr == A_STAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            cmp_a_q <= '0;
            cmp_c_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_MODE:  mode_q  <= mode_t'(bus_wdata[MODE_W-1:0]);
                A_CMPA:  cmp_a_q <= bus_wdata;
                A_CMPC:  cmp_c_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    wtc_tick_gen #(.NUM_DIV(NUM_DIV), .DIV_LOG(DIV_LOG)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctl.clr),
        .src    (mode_q.src),
        .ext_in (chain_in),
        .tick   (tick)
    );

    wtc_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .ctl       (ctl),
        .reload    (mode_q.reload),
        .stop_on_c (mode_q.stop_on_c),
        .cmp_a     (cmp_a_q),
        .cmp_c     (cmp_c_q),
        .cnt       (cnt),
        .running   (running),
        .wave      (wave_out),
        .evt       (evt)
    );

    wtc_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rd_clear (rd_clear),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .flags    (flags),
        .mask     (mask),
        .irq      (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:  bus_rdata = CNT_W'(mode_q);
            A_CMPA:  bus_rdata = cmp_a_q;
            A_CMPC:  bus_rdata = cmp_c_q;
            A_COUNT: bus_rdata = cnt;
            A_STAT: begin
                bus_rdata[EVT_W-1:0] = flags;
                bus_rdata[ST_RUN]    = running;
                bus_rdata[ST_WAVE]   = wave_out;
            end
            A_IMASK: bus_rdata = CNT_W'(mask);
            default: bus_rdata = '0;
        endcase
    end

    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (cnt == '0)); // R12

endmodule

// File: tb/wtc_channel_tb.sv
module wtc_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd, sync_in, chain_in;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        wave_out, irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    wtc_channel dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sync_in   (sync_in),
        .chain_in  (chain_in),
        .wave_out  (wave_out),
        .irq_out   (irq_out)
    );

    localparam logic [3:0] CMD = 0, MODE = 1, CMPA = 2, CMPC = 3, COUNT = 4,
                           STAT = 5, ISET = 6, ICLR = 7, IMASK = 8;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic park;
        logic [15:0] v;
        wr(CMD, 16'h0002);
        rd(STAT, v);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 wave", wave_out, 0);
        check("R1 irq", irq_out, 0);
        rd(COUNT, v); check("R1 count", v, 0);
        rd(STAT, v);  check("R1 status", v, 0);
        rd(IMASK, v); check("R1 mask", v, 0);
        rd(MODE, v);  check("R1 mode", v, 0);
    endtask

    task automatic t_freerun;
        logic [15:0] v;
        int hi = 0;
        wr(CMPA, 16'h0000);
        wr(CMPC, 16'h8000);
        wr(MODE, 16'h0000);
        wr(CMD, 16'h0005);
        for (int k = 0; k < 65536; k++) begin
            if (wave_out) hi++;
            @(negedge clk);
        end
        check("R6 duty half", hi, 32768);
        rd(STAT, v); check("R2 wrap flag with a/c flags", v, 16'h0107);
        rd(STAT, v); check("R7 same-edge event survives read", v, 16'h0302);
        rd(COUNT, v); check("R2 count after wrap", v, 2);
        park();
    endtask

    task automatic t_reload;
        logic [15:0] v;
        wr(CMPA, 16'd1);
        wr(CMPC, 16'd3);
        wr(MODE, 16'h0008);
        wr(CMD, 16'h0005);
        for (int k = 1; k <= 8; k++) begin
            if (k >= 3) check("R6 wave in reload", wave_out, (((k-1) % 4) >= 2) ? 1 : 0);
            rd(COUNT, v);
            check("R3 reload sequence", v, (k-1) % 4);
        end
        park();
    endtask

    task automatic t_oneshot;
        logic [15:0] v;
        wr(CMPA, 16'h0100);
        wr(CMPC, 16'd2);
        wr(MODE, 16'h0018);
        wr(ISET, 16'h0004);
        wr(CMD, 16'h0005);
        check("R9 irq idle", irq_out, 0);
        idle(2);
        check("R9 irq before match", irq_out, 0);
        idle(1);
        check("R9 irq on match", irq_out, 1);
        wr(ICLR, 16'h00FF);
        check("R8 irq masked", irq_out, 0);
        rd(IMASK, v); check("R8 mask cleared", v, 0);
        wr(ISET, 16'h0004);
        check("R9 irq unmasked", irq_out, 1);
        rd(STAT, v); check("R4 stopped with c flag", v, 16'h0004);
        check("R7 read clears flag", irq_out, 0);
        rd(COUNT, v); check("R4 count at zero", v, 0);
        idle(10);
        rd(COUNT, v); check("R4 count holds", v, 0);
        wr(CMD, 16'h0005);
        idle(1);
        rd(COUNT, v); check("R4 restart", v, 1);
        wr(ICLR, 16'h00FF);
        park();
    endtask

    task automatic t_mask;
        logic [15:0] v;
        wr(ISET, 16'h0007);
        rd(IMASK, v); check("R8 set all", v, 7);
        wr(ICLR, 16'h0002);
        rd(IMASK, v); check("R8 clear one", v, 5);
        wr(ICLR, 16'h00FF);
        rd(IMASK, v); check("R8 clear all", v, 0);
    endtask

    task automatic t_halt;
        logic [15:0] v;
        wr(MODE, 16'h0000);
        wr(CMD, 16'h0005);
        idle(3);
        wr(CMD, 16'h0002);
        rd(COUNT, v); check("R5 halted count", v, 4);
        idle(3);
        rd(COUNT, v); check("R5 count frozen", v, 4);
        rd(STAT, v); check("R5 running clear", v[8], 0);
        wr(CMD, 16'h0007);
        rd(COUNT, v); check("R5 trigger zeroes", v, 0);
        idle(2);
        rd(COUNT, v); check("R5 halt beats start", v, 0);
        wr(CMD, 16'h0001);
        rd(COUNT, v); check("R5 start no trigger", v, 0);
        rd(COUNT, v); check("R5 start counts", v, 1);
        park();
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        wr(MODE, 16'h0001);
        wr(CMD, 16'h0005);
        idle(39);
        rd(COUNT, v); check("R10 div4 count", v, 9);
        rd(COUNT, v); check("R10 div4 step", v, 10);
        park();
        wr(MODE, 16'h0002);
        wr(CMD, 16'h0005);
        idle(31);
        rd(COUNT, v); check("R10 div16 count", v, 1);
        rd(COUNT, v); check("R10 div16 step", v, 2);
        park();
    endtask

    task automatic t_sync;
        logic [15:0] v;
        wr(MODE, 16'h0000);
        wr(CMD, 16'h0005);
        idle(9);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        rd(COUNT, v); check("R12 sync zeroes", v, 0);
        rd(COUNT, v); check("R12 counts on", v, 1);
        park();
    endtask

    task automatic t_chain;
        logic [15:0] v;
        chain_in = 1'b0;
        wr(MODE, 16'h0004);
        idle(4);
        wr(CMD, 16'h0005);
        for (int p = 0; p < 5; p++) begin
            chain_in = 1'b1; idle(3);
            chain_in = 1'b0; idle(3);
        end
        idle(3);
        rd(COUNT, v); check("R11 edges counted", v, 5);
        chain_in = 1'b1;
        idle(2);
        rd(COUNT, v); check("R11 not yet", v, 5);
        rd(COUNT, v); check("R11 after three edges", v, 6);
        idle(5);
        rd(COUNT, v); check("R11 level no count", v, 6);
        chain_in = 1'b0;
        park();
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
        bus_wdata = '0; sync_in = 1'b0; chain_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_freerun();
        t_reload();
        t_oneshot();
        t_mask();
        t_halt();
        t_prescale();
        t_sync();
        t_chain();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule